// File: doc/BRIEF.md
# Two-Bank Receive Block Buffer With Host Release

This block sits between a serial frame receiver and a host bus. It holds up to 64 bytes as two 32-byte banks. The receiver fills the banks in turn. The host sees one completed bank at a time, called the visible block. The host can read any byte of the visible block by address, as often as it likes. The block stays frozen until the host releases it. The other bank keeps filling in the background.

The host is told about a new visible block in one of two ways. In interrupt mode it gets a one-cycle pool-full pulse. If the frame ended early, it gets a message-end pulse instead. In DMA mode a request line rises, and each acknowledge reads the next byte in order.

The host releases a block with an explicit confirm command. In DMA mode the release also happens by itself once every byte of the block has been transferred. After a release, the next completed bank becomes visible.

On the receiver side, `in_valid`/`in_ready` form the byte stream. A byte is taken on a clock edge where both are high. The receiver cannot be stalled. A byte offered while `in_ready` is low is discarded and sets a sticky overflow flag. The mode input is static and may be changed only while the buffer is empty.

Top module: `rx_dual_half_buf`

## Requirements
- R1: After reset, `in_ready`=1 and `blk_count`=0. `blk_eom`, `irq_pool`, `irq_msg`, `dma_req`, `rd_valid` and `overflow` are all 0.
- R2: Once 32 bytes without end-of-frame have been taken, that bank becomes the visible block with `blk_count`=32. In interrupt mode (`dma_mode`=0), `irq_pool` is high for exactly the one cycle after the edge that took the 32nd byte.
- R3: A host read (`rd_en`, `rd_addr` 0..31) while a block is visible returns, on the next cycle, `rd_valid`=1 and `rd_data` equal to the byte taken at that position. Reads in interrupt mode do not change the block, so repeated reads return the same byte.
- R4: `confirm` while a block is visible releases it. If the other bank is already complete, it becomes visible in the next cycle, with a new notification pulse. Otherwise `blk_count` returns to 0.
- R5: `confirm` while no block is visible has no effect. The next frame is stored and reported normally.
- R6: `in_last` with a taken byte ends the block early. `blk_count` then reports its length (1..32), `blk_eom` is 1, and `irq_msg` pulses for one cycle in either mode instead of `irq_pool`.
- R7: A 64-byte frame is held whole as two blocks. While both banks hold unreleased blocks, `in_ready` is 0. When no block is visible, `in_ready` is 1.
- R8: A byte offered while `in_ready`=0 is discarded without reaching either bank. It sets `overflow`, which stays 1 until reset.
- R9: In DMA mode, `dma_req` is high while the visible block has untransferred bytes. After each accepted acknowledge (`dma_ack` while `dma_req`=1), `dma_req` is low for exactly one cycle and then high again if bytes remain. An acknowledge while `dma_req`=0 is ignored.
- R10: Each accepted acknowledge returns the next byte of the visible block in ascending order, on `rd_data` with `rd_valid`=1 in the following cycle.
- R11: In DMA mode, the block is released by itself after `blk_count` accepted acknowledges, and `irq_pool` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_mode | input | 1 | 0 = interrupt mode, 1 = DMA mode (static) |
| in_valid | input | 1 | Receiver byte valid |
| in_ready | output | 1 | A free bank can take the byte |
| in_data | input | 8 | Receiver byte |
| in_last | input | 1 | Byte is the final byte of the frame |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 5 | Byte position within the visible block |
| rd_data | output | 8 | Read result, registered |
| rd_valid | output | 1 | `rd_data` holds a fresh result |
| confirm | input | 1 | Release command for the visible block |
| blk_count | output | 6 | Byte count of the visible block, 0 if none |
| blk_eom | output | 1 | Visible block ends a frame |
| irq_pool | output | 1 | One-cycle pulse: a full block is visible (interrupt mode) |
| irq_msg | output | 1 | One-cycle pulse: a frame-ending block is visible |
| dma_req | output | 1 | DMA transfer request |
| dma_ack | input | 1 | DMA transfer acknowledge |
| overflow | output | 1 | Sticky: a byte was discarded |

## Verification
The bench fills both banks and then offers one more byte. A design that wrote that byte over either bank would show it in the second block or in the next frame. A design that let `in_ready` stay high would not raise `overflow`.

It re-reads the same addresses before confirming, which catches a design that pops bytes on read. It also confirms when the buffer is empty, which would desynchronize a bank pointer that does not check for a visible block.

In DMA mode it checks three things:
- the one-cycle gap in `dma_req` after every acknowledge;
- that an acknowledge placed inside that gap is ignored, since honouring it would skip a byte;
- that the block is released after exactly `blk_count` transfers, both for full and for short blocks.

// File: rtl/rxh_pkg.sv
`timescale 1ns/1ps
package rxh_pkg;
  // default geometry of one bank
  localparam int unsigned RXH_BANK_BYTES = 32;
  localparam int unsigned RXH_DATA_W     = 8;

  typedef enum logic {
    RXH_MODE_IRQ = 1'b0,
    RXH_MODE_DMA = 1'b1
  } rxh_mode_e;
endpackage

// File: rtl/rxh_bank.sv
`timescale 1ns/1ps
// Two byte banks: one write port, one registered read port.
module rxh_bank #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          re,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end

    assign bank_q[b] = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (re) rd_data <= bank_q[rd_bank];
  end
endmodule

// File: rtl/rxh_fill.sv
`timescale 1ns/1ps
// Receiver side: fills the tail bank and records block descriptors.
module rxh_fill #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          space,
  output logic          take,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          blk_done,
  output logic [CW-1:0] desc_cnt [2],
  output logic          desc_eom [2],
  output logic          ovf
);
  logic          tail;
  logic [AW-1:0] fcnt;

  assign take     = in_valid && space;
  assign wr_bank  = tail;
  assign wr_addr  = fcnt;
  assign blk_done = take && (in_last || (fcnt == AW'(DEPTH - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail <= 1'b0;
      fcnt <= '0;
      ovf  <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        desc_cnt[b] <= '0;
        desc_eom[b] <= 1'b0;
      end
    end else begin
      if (in_valid && !space) ovf <= 1'b1;
      if (blk_done) begin
        desc_cnt[tail] <= CW'(fcnt) + CW'(1);
        desc_eom[tail] <= in_last;
        tail           <= ~tail;
        fcnt           <= '0;
      end else if (take) begin
        fcnt <= fcnt + AW'(1);
      end
    end
  end
endmodule

// File: rtl/rxh_host.sv
`timescale 1ns/1ps
// Host side: visible block tracking, release, notification, DMA sequencing.
module rxh_host #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  rxh_pkg::rxh_mode_e mode,
  input  logic           blk_done,
  input  logic           confirm,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr_in,
  input  logic           dma_ack,
  input  logic [CW-1:0]  head_cnt,
  input  logic           head_eom,
  output logic           head,
  output logic           space,
  output logic           re,
  output logic [AW-1:0]  rd_addr,
  output logic           rd_valid,
  output logic           irq_pool,
  output logic           irq_msg,
  output logic           dma_req,
  output logic [CW-1:0]  blk_count,
  output logic           blk_eom
);
  import rxh_pkg::*;

  logic [1:0]    nblk;
  logic [CW-1:0] dptr;
  logic          shown;
  logic          ack_seen;
  logic          pending;
  logic          dma_go;
  logic          release_blk;
  logic          is_dma;

  assign is_dma  = (mode == RXH_MODE_DMA);
  assign pending = (nblk != 2'd0);
  assign space   = (nblk != 2'd2);

  assign dma_req = is_dma && pending && !ack_seen && (dptr < head_cnt);
  assign dma_go  = dma_ack && dma_req;

  assign release_blk = pending &&
                       (confirm || (dma_go && ((dptr + CW'(1)) == head_cnt)));

  assign re      = pending && (dma_go || rd_en);
  assign rd_addr = dma_go ? dptr[AW-1:0] : rd_addr_in;

  assign irq_pool  = pending && !shown && !is_dma && !head_eom;
  assign irq_msg   = pending && !shown && head_eom;
  assign blk_count = pending ? head_cnt : '0;
  assign blk_eom   = pending && head_eom;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nblk     <= 2'd0;
      head     <= 1'b0;
      dptr     <= '0;
      shown    <= 1'b0;
      ack_seen <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      nblk     <= nblk + 2'(blk_done) - 2'(release_blk);
      ack_seen <= dma_go;
      rd_valid <= re;
      if (release_blk) begin
        head  <= ~head;
        dptr  <= '0;
        shown <= 1'b0;
      end else begin
        if (dma_go)  dptr  <= dptr + CW'(1);
        if (pending) shown <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_dual_half_buf.sv
`timescale 1ns/1ps
module rx_dual_half_buf #(
  parameter int unsigned DW    = rxh_pkg::RXH_DATA_W,
  parameter int unsigned DEPTH = rxh_pkg::RXH_BANK_BYTES,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          confirm,
  output logic [CW-1:0] blk_count,
  output logic          blk_eom,
  output logic          irq_pool,
  output logic          irq_msg,
  output logic          dma_req,
  input  logic          dma_ack,
  output logic          overflow
);
  import rxh_pkg::*;

  logic          space, take, wr_bank, blk_done, head, re;
  logic [AW-1:0] wr_addr, bank_rd_addr;
  logic [CW-1:0] desc_cnt [2];
  logic          desc_eom [2];
  rxh_mode_e     mode;

  assign mode     = rxh_mode_e'(dma_mode);
  assign in_ready = space;

  rxh_fill #(.DEPTH(DEPTH)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .space    (space),
    .take     (take),
    .wr_bank  (wr_bank),
    .wr_addr  (wr_addr),
    .blk_done (blk_done),
    .desc_cnt (desc_cnt),
    .desc_eom (desc_eom),
    .ovf      (overflow)
  );

  rxh_host #(.DEPTH(DEPTH)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .blk_done   (blk_done),
    .confirm    (confirm),
    .rd_en      (rd_en),
    .rd_addr_in (rd_addr),
    .dma_ack    (dma_ack),
    .head_cnt   (desc_cnt[head]),
    .head_eom   (desc_eom[head]),
    .head       (head),
    .space      (space),
    .re         (re),
    .rd_addr    (bank_rd_addr),
    .rd_valid   (rd_valid),
    .irq_pool   (irq_pool),
    .irq_msg    (irq_msg),
    .dma_req    (dma_req),
    .blk_count  (blk_count),
    .blk_eom    (blk_eom)
  );

  rxh_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
    .clk     (clk),
    .we      (take),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .re      (re),
    .rd_bank (head),
    .rd_addr (bank_rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rxh_chk.sv
`timescale 1ns/1ps
module rxh_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_mode,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          confirm,
  input logic [CW-1:0] blk_count,
  input logic          irq_pool,
  input logic          irq_msg,
  input logic          dma_req,
  input logic          dma_ack,
  input logic          overflow
);
  assert_one_note_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pool && irq_msg));

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_count <= CW'(DEPTH));

  assert_read_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && blk_count != '0) |=> rd_valid);

  assert_idle_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm && blk_count == '0 && !in_valid) |=> (blk_count == '0));

  assert_empty_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_count == '0) |-> in_ready);

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_req_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && dma_req) |=> !dma_req);

  assert_req_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> !dma_req);

  assert_dma_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && dma_req) |=> rd_valid);

  assert_no_pool_dma_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> !irq_pool);
endmodule

bind rx_dual_half_buf rxh_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dma_mode  (dma_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .confirm   (confirm),
  .blk_count (blk_count),
  .irq_pool  (irq_pool),
  .irq_msg   (irq_msg),
  .dma_req   (dma_req),
  .dma_ack   (dma_ack),
  .overflow  (overflow)
);

// File: tb/tb_rx_dual_half_buf.sv
`timescale 1ns/1ps
module tb_rx_dual_half_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       confirm = 1'b0;
  logic [5:0] blk_count;
  logic       blk_eom;
  logic       irq_pool;
  logic       irq_msg;
  logic       dma_req;
  logic       dma_ack = 1'b0;
  logic       overflow;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  rx_dual_half_buf dut (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .confirm(confirm), .blk_count(blk_count), .blk_eom(blk_eom),
    .irq_pool(irq_pool), .irq_msg(irq_msg), .dma_req(dma_req),
    .dma_ack(dma_ack), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; dma_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] base, input int n, input logic last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = base + 8'(i); in_last = last && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic host_rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, int'(rd_valid), 1);
    check(req, int'(rd_data), int'(exp));
  endtask

  task automatic do_confirm();
    @(negedge clk);
    confirm = 1'b1;
    @(negedge clk);
    confirm = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 blk_count", int'(blk_count), 0);
    check("R1 flags", int'({blk_eom, irq_pool, irq_msg, dma_req, rd_valid, overflow}), 0);
  endtask

  task automatic t_idle_confirm();
    do_confirm();
    check("R5 count after idle confirm", int'(blk_count), 0);
    check("R5 no note", int'({irq_pool, irq_msg}), 0);
    push(8'h20, 2, 1'b1);
    check("R5 next frame count", int'(blk_count), 2);
    check("R5 next frame note R6", int'(irq_msg), 1);
    host_rd(5'd1, 8'h21, "R5 next frame data");
    do_confirm();
  endtask

  task automatic t_full_block();
    push(8'h40, 32, 1'b0);
    check("R2 irq_pool pulse", int'(irq_pool), 1);
    check("R2 no msg", int'(irq_msg), 0);
    check("R2 count", int'(blk_count), 32);
    @(negedge clk);
    check("R2 pulse one cycle", int'(irq_pool), 0);
    host_rd(5'd0, 8'h40, "R3 addr0");
    host_rd(5'd31, 8'h5F, "R3 addr31");
    host_rd(5'd7, 8'h47, "R3 addr7");
    host_rd(5'd0, 8'h40, "R3 reread addr0");
    check("R3 count unchanged", int'(blk_count), 32);
    do_confirm();
    check("R4 released", int'(blk_count), 0);
  endtask

  task automatic t_short_frame();
    push(8'h60, 5, 1'b1);
    check("R6 count", int'(blk_count), 5);
    check("R6 eom", int'(blk_eom), 1);
    check("R6 msg not pool", int'({irq_msg, irq_pool}), 2);
    host_rd(5'd4, 8'h64, "R6 last byte");
    do_confirm();
  endtask

  task automatic t_two_blocks_overflow();
    push(8'h80, 64, 1'b0);
    check("R7 count", int'(blk_count), 32);
    check("R7 not ready", int'(in_ready), 0);
    check("R8 no ovf yet", int'(overflow), 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 overflow set", int'(overflow), 1);
    host_rd(5'd5, 8'h85, "R8 first block intact");
    do_confirm();
    check("R4 new note", int'(irq_pool), 1);
    check("R4 second count", int'(blk_count), 32);
    check("R7 ready again", int'(in_ready), 1);
    host_rd(5'd0, 8'hA0, "R7 second block head");
    host_rd(5'd31, 8'hBF, "R8 second block tail");
    do_confirm();
    check("R4 empty", int'(blk_count), 0);
    push(8'h11, 1, 1'b1);
    check("R8 dropped byte absent count", int'(blk_count), 1);
    host_rd(5'd0, 8'h11, "R8 dropped byte absent data");
    do_confirm();
    check("R8 sticky", int'(overflow), 1);
    do_reset(1'b0);
    check("R1 overflow cleared", int'(overflow), 0);
  endtask

  task automatic t_dma_full();
    do_reset(1'b1);
    push(8'hC0, 32, 1'b0);
    check("R9 req up", int'(dma_req), 1);
    check("R11 no pool", int'(irq_pool), 0);
    for (int i = 0; i < 32; i++) begin
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      check("R10 valid", int'(rd_valid), 1);
      check("R10 data", int'(rd_data), int'(8'hC0 + 8'(i)));
      check("R9 gap", int'(dma_req), 0);
      if (i == 0) begin
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        check("R9 ignored ack", int'(rd_valid), 0);
      end else begin
        @(negedge clk);
      end
      check("R9 req back", int'(dma_req), (i == 31) ? 0 : 1);
    end
    check("R11 implicit release", int'(blk_count), 0);
  endtask

  task automatic t_dma_short();
    push(8'h30, 3, 1'b1);
    check("R6 dma msg", int'(irq_msg), 1);
    check("R11 dma short count", int'(blk_count), 3);
    for (int i = 0; i < 3; i++) begin
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      check("R10 short data", int'(rd_data), int'(8'h30 + 8'(i)));
      @(negedge clk);
    end
    check("R11 short release", int'(blk_count), 0);
    check("R9 req idle", int'(dma_req), 0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_idle_confirm();
    t_full_block();
    t_short_frame();
    t_two_blocks_overflow();
    t_dma_full();
    t_dma_short();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule